// File: doc/BRIEF.md
# Multi-CPU Soft Reset Controller

This block generates power-on and externally initiated resets for a system of four processors and records why the last reset of each kind happened. Software reaches it through a small byte-wide register bus. Each bus access carries the number of the requesting processor, and a per-processor access-enable mask decides whether that access is honoured. Writing a soft reset register starts a fixed-length pulse on the selected per-CPU reset lines, or on the system reset line. The bits then clear by themselves.

External requests also start reset pulses. These come from a watchdog, a reset push-button, a debug port, seven fatal-error lines, a clock-synthesizer update strobe and a remote monitor. A watchdog action bit decides whether the watchdog is acted on. Four quiesce bits can silence the processor fatal-error lines. Every cycle in which an external input is high counts as one event.

The source registers are sticky. They change only when a new event of their kind arrives. At that point they are cleared and reloaded with every cause present in that cycle, so they always describe the most recent reset.

Top module: `srst_ctrl`

## Requirements
- R1: After cold reset all reset outputs are low. The access mask (address 1) reads 0x0F, and quiesce (address 2) and watchdog action (address 3) read 0. The power-on source reads 0x000080, with only bit 7 (power-up) set. The externally-initiated source (address 9) reads 0.
- R2: Writing address 4 with bits 3:0 set drives the matching cpu_por_o bits high. They rise in the cycle after the write edge, stay high for exactly 16 cycles and then clear by themselves. While active they read back in bits 3:0 of address 4.
- R3: Writing address 4 with bit 4 set drives sys_rst_o and all four cpu_por_o bits high for 16 cycles. Whenever sys_rst_o is high, every cpu_por_o bit is high.
- R4: Writing address 5 with bits 3:0 set drives the matching cpu_xir_o bits for 16 cycles, after which they clear by themselves.
- R5: Any power-on event clears the 18-bit power-on source and loads it with the causes of that cycle. The bit map is:
  - bits 3:0: soft per-CPU reset;
  - bit 4: soft system reset;
  - bit 5: debug port;
  - bit 6: button;
  - bit 7: power-up;
  - bits 14:8: fatal_i[6:0];
  - bit 15: synthesizer update;
  - bit 16: watchdog;
  - bit 17: remote monitor.

  It is read as bits 7:0 at address 6, bits 15:8 at address 7 and bits 17:16 at address 8. Without a new event it holds its value.
- R6: Any externally-initiated reset event reloads the 6-bit source at address 9 in the same way. Bits 3:0 are soft per-CPU requests, bit 4 is a debug-port request and bit 5 is a reset-button request. Debug-port and reset-button requests drive all four cpu_xir_o bits for 16 cycles.
- R7: When bit 0 of address 3 is set, a high wdog_i produces a 16-cycle system reset and source bit 16. When the bit is clear, wdog_i has no effect on the outputs or the source.
- R8: A high button_i, dbg_por_i, synth_i, remote_i or unmasked fatal_i bit produces a 16-cycle system reset.
- R9: Bits 7:4 of address 2 mask fatal_i[3:0]. A masked input neither resets nor sets a source bit. Bits 3:0 of address 2 are stored and read back only.
- R10: Bits 3:0 of address 1 enable bus access for CPU 0–3. A write from a disabled CPU is ignored, and a read from it returns 0.
- R11: Address 0 returns cpu_present_i in bits 3:0 and ignores writes. Addresses 10 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low cold reset |
| bus_req | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_cpu | input | 2 | Number of the requesting processor |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of a read |
| cpu_present_i | input | 4 | Processor presence flags |
| wdog_i | input | 1 | Watchdog expiry |
| button_i | input | 1 | Power-on reset push-button |
| dbg_por_i | input | 1 | Debug port system reset request |
| dbg_xir_i | input | 1 | Debug port external reset request to all CPUs |
| xir_button_i | input | 1 | External reset push-button, all CPUs |
| fatal_i | input | 7 | Fatal-error lines, 3:0 from the processors |
| synth_i | input | 1 | Clock synthesizer update strobe |
| remote_i | input | 1 | Remote monitor reset request |
| cpu_por_o | output | 4 | Per-CPU power-on reset |
| cpu_xir_o | output | 4 | Per-CPU externally initiated reset |
| sys_rst_o | output | 1 | System reset |

## Verification
The hardest cases are the ones where an input must leave no trace. These are a watchdog expiry while the action bit is clear, a processor fatal line whose quiesce bit is set, and a bus access from a processor whose enable bit is off. In each case the only evidence is that the sticky source and the reset lines stay as they were. The stimulus therefore first loads a known, distinctive cause into the source through a different event. It then applies the suppressed input, and checks both the reset outputs and all three source bytes. The random phase re-randomizes the mask and the watchdog enable before each event, so suppressed and honoured events alternate against a tracked model of the source.

// File: rtl/srst_pkg.sv
package srst_pkg;
    localparam int NCPU     = 4;
    localparam int NFATAL   = 7;
    localparam int PSRC_W   = 18;
    localparam int XSRC_W   = 6;
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 8;

    localparam logic [ADDR_W-1:0] A_PRESENT = 4'd0;
    localparam logic [ADDR_W-1:0] A_ACCESS  = 4'd1;
    localparam logic [ADDR_W-1:0] A_QUIESCE = 4'd2;
    localparam logic [ADDR_W-1:0] A_WDOG    = 4'd3;
    localparam logic [ADDR_W-1:0] A_SPOR    = 4'd4;
    localparam logic [ADDR_W-1:0] A_SXIR    = 4'd5;
    localparam logic [ADDR_W-1:0] A_PSRC0   = 4'd6;
    localparam logic [ADDR_W-1:0] A_PSRC1   = 4'd7;
    localparam logic [ADDR_W-1:0] A_PSRC2   = 4'd8;
    localparam logic [ADDR_W-1:0] A_XSRC    = 4'd9;

    // power-on source bit positions
    localparam int PB_SYS    = 4;
    localparam int PB_DBG    = 5;
    localparam int PB_BUTTON = 6;
    localparam int PB_PWRUP  = 7;
    localparam int PB_FATAL  = 8;
    localparam int PB_SYNTH  = 15;
    localparam int PB_WDOG   = 16;
    localparam int PB_REMOTE = 17;

    localparam logic [PSRC_W-1:0] PSRC_COLD = PSRC_W'(1) << PB_PWRUP;
endpackage

// File: rtl/srst_pulse.sv
module srst_pulse #(
    parameter int N   = 4,
    parameter int LEN = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fire,
    input  logic [N-1:0] bits_i,
    output logic [N-1:0] act_o
);
    localparam int CW = $clog2(LEN + 1);

    typedef struct packed {
        logic [N-1:0]  bits;
        logic [CW-1:0] cnt;
    } pulse_st_t;

    pulse_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire) begin
            st_d.bits = st_q.bits | bits_i;
            st_d.cnt  = CW'(LEN);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CW'(1)) begin
                st_d.bits = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_o = st_q.bits;
endmodule

// File: rtl/srst_regs.sv
module srst_regs
    import srst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [1:0]        bus_cpu,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NCPU-1:0]   present_i,
    input  logic [PSRC_W-1:0] psrc_i,
    input  logic [XSRC_W-1:0] xsrc_i,
    input  logic [NCPU-1:0]   por_act_i,
    input  logic              sys_act_i,
    input  logic [NCPU-1:0]   xir_act_i,
    output logic [NCPU-1:0]   access_o,
    output logic [NCPU-1:0]   fat_mask_o,
    output logic              wd_en_o,
    output logic              spor_wr_o,
    output logic              sxir_wr_o
);
    typedef struct packed {
        logic [NCPU-1:0]   access;
        logic [DATA_W-1:0] quiesce;
        logic              wd_en;
    } cfg_st_t;

    cfg_st_t cfg_d, cfg_q;
    logic    acc_ok;
    logic    wr_ok;
    logic    rd_ok;

    always_comb begin
        acc_ok    = cfg_q.access[bus_cpu];
        wr_ok     = bus_req && bus_we && acc_ok;
        rd_ok     = bus_req && !bus_we && acc_ok;
        cfg_d     = cfg_q;
        spor_wr_o = 1'b0;
        sxir_wr_o = 1'b0;
        if (wr_ok) begin
            case (bus_addr)
                A_ACCESS:  cfg_d.access  = bus_wdata[NCPU-1:0];
                A_QUIESCE: cfg_d.quiesce = bus_wdata;
                A_WDOG:    cfg_d.wd_en   = bus_wdata[0];
                A_SPOR:    spor_wr_o     = 1'b1;
                A_SXIR:    sxir_wr_o     = 1'b1;
                default:   ;
            endcase
        end
        bus_rdata = '0;
        if (rd_ok) begin
            case (bus_addr)
                A_PRESENT: bus_rdata = DATA_W'(present_i);
                A_ACCESS:  bus_rdata = DATA_W'(cfg_q.access);
                A_QUIESCE: bus_rdata = cfg_q.quiesce;
                A_WDOG:    bus_rdata = DATA_W'(cfg_q.wd_en);
                A_SPOR:    bus_rdata = DATA_W'({sys_act_i, por_act_i});
                A_SXIR:    bus_rdata = DATA_W'(xir_act_i);
                A_PSRC0:   bus_rdata = psrc_i[7:0];
                A_PSRC1:   bus_rdata = psrc_i[15:8];
                A_PSRC2:   bus_rdata = DATA_W'(psrc_i[PSRC_W-1:16]);
                A_XSRC:    bus_rdata = DATA_W'(xsrc_i);
                default:   bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.access  <= '1;
            cfg_q.quiesce <= '0;
            cfg_q.wd_en   <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign access_o   = cfg_q.access;
    assign fat_mask_o = cfg_q.quiesce[DATA_W-1:DATA_W-NCPU];
    assign wd_en_o    = cfg_q.wd_en;
endmodule

// File: rtl/srst_cause.sv
module srst_cause
    import srst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_fire,
    input  logic [PSRC_W-1:0] por_cause,
    input  logic              xir_fire,
    input  logic [XSRC_W-1:0] xir_cause,
    output logic [PSRC_W-1:0] psrc_o,
    output logic [XSRC_W-1:0] xsrc_o
);
    typedef struct packed {
        logic [PSRC_W-1:0] psrc;
        logic [XSRC_W-1:0] xsrc;
    } src_st_t;

    src_st_t src_d, src_q;

    always_comb begin
        src_d = src_q;
        if (por_fire) begin
            src_d.psrc = por_cause;
        end
        if (xir_fire) begin
            src_d.xsrc = xir_cause;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q.psrc <= PSRC_COLD;
            src_q.xsrc <= '0;
        end else begin
            src_q <= src_d;
        end
    end

    assign psrc_o = src_q.psrc;
    assign xsrc_o = src_q.xsrc;
endmodule

// File: rtl/srst_ctrl.sv
module srst_ctrl
    import srst_pkg::*;
#(
    parameter int PULSE_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [1:0]        bus_cpu,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NCPU-1:0]   cpu_present_i,
    input  logic              wdog_i,
    input  logic              button_i,
    input  logic              dbg_por_i,
    input  logic              dbg_xir_i,
    input  logic              xir_button_i,
    input  logic [NFATAL-1:0] fatal_i,
    input  logic              synth_i,
    input  logic              remote_i,
    output logic [NCPU-1:0]   cpu_por_o,
    output logic [NCPU-1:0]   cpu_xir_o,
    output logic              sys_rst_o
);
    logic [NCPU-1:0]   access_w;
    logic [NCPU-1:0]   fat_mask_w;
    logic              wd_en_w;
    logic              spor_wr_w;
    logic              sxir_wr_w;
    logic [PSRC_W-1:0] psrc_w;
    logic [XSRC_W-1:0] xsrc_w;
    logic [NCPU-1:0]   por_act_w;
    logic [NCPU-1:0]   xir_act_w;
    logic              sys_act_w;

    logic [NCPU-1:0]   soft_por_cpu;
    logic              soft_sys;
    logic [NCPU-1:0]   soft_xir_cpu;
    logic [NFATAL-1:0] fat_ok;
    logic [PSRC_W-1:0] por_cause;
    logic [XSRC_W-1:0] xir_cause;
    logic [NCPU-1:0]   xir_bits;
    logic              sys_fire;
    logic              cpu_fire;
    logic              xir_fire;

    always_comb begin
        soft_por_cpu = spor_wr_w ? bus_wdata[NCPU-1:0] : '0;
        soft_sys     = spor_wr_w && bus_wdata[NCPU];
        soft_xir_cpu = sxir_wr_w ? bus_wdata[NCPU-1:0] : '0;
        fat_ok       = fatal_i & ~{{(NFATAL-NCPU){1'b0}}, fat_mask_w};

        por_cause                          = '0;
        por_cause[NCPU-1:0]                = soft_por_cpu;
        por_cause[PB_SYS]                  = soft_sys;
        por_cause[PB_DBG]                  = dbg_por_i;
        por_cause[PB_BUTTON]               = button_i;
        por_cause[PB_FATAL+NFATAL-1:PB_FATAL] = fat_ok;
        por_cause[PB_SYNTH]                = synth_i;
        por_cause[PB_WDOG]                 = wdog_i && wd_en_w;
        por_cause[PB_REMOTE]               = remote_i;

        sys_fire  = |por_cause[PSRC_W-1:PB_SYS];
        cpu_fire  = |soft_por_cpu;

        xir_cause = {xir_button_i, dbg_xir_i, soft_xir_cpu};
        xir_fire  = |xir_cause;
        xir_bits  = soft_xir_cpu | {NCPU{xir_button_i | dbg_xir_i}};
    end

    srst_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_cpu    (bus_cpu),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .present_i  (cpu_present_i),
        .psrc_i     (psrc_w),
        .xsrc_i     (xsrc_w),
        .por_act_i  (por_act_w),
        .sys_act_i  (sys_act_w),
        .xir_act_i  (xir_act_w),
        .access_o   (access_w),
        .fat_mask_o (fat_mask_w),
        .wd_en_o    (wd_en_w),
        .spor_wr_o  (spor_wr_w),
        .sxir_wr_o  (sxir_wr_w)
    );

    srst_cause u_cause (
        .clk       (clk),
        .rst_n     (rst_n),
        .por_fire  (sys_fire || cpu_fire),
        .por_cause (por_cause),
        .xir_fire  (xir_fire),
        .xir_cause (xir_cause),
        .psrc_o    (psrc_w),
        .xsrc_o    (xsrc_w)
    );

    srst_pulse #(.N(NCPU), .LEN(PULSE_LEN)) u_por_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (cpu_fire),
        .bits_i (soft_por_cpu),
        .act_o  (por_act_w)
    );

    srst_pulse #(.N(1), .LEN(PULSE_LEN)) u_sys_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (sys_fire),
        .bits_i (1'b1),
        .act_o  (sys_act_w)
    );

    srst_pulse #(.N(NCPU), .LEN(PULSE_LEN)) u_xir_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (xir_fire),
        .bits_i (xir_bits),
        .act_o  (xir_act_w)
    );

    assign sys_rst_o = sys_act_w;
    assign cpu_por_o = por_act_w | {NCPU{sys_act_w}};
    assign cpu_xir_o = xir_act_w;
endmodule

// File: rtl/srst_ctrl_chk.sv
module srst_ctrl_chk
    import srst_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [1:0]        bus_cpu,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NCPU-1:0]   access_w,
    input logic [PSRC_W-1:0] psrc_w,
    input logic [XSRC_W-1:0] xsrc_w,
    input logic [NCPU-1:0]   cpu_por_o,
    input logic [NCPU-1:0]   cpu_xir_o,
    input logic              sys_rst_o
);
    // R3
    sys_covers_cpus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |-> (&cpu_por_o));

    // R3
    sys_min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |=> sys_rst_o);

    // R4
    xir_min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|cpu_xir_o) |=> (|cpu_xir_o));

    // R5
    psrc_never_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psrc_w != '0);

    // R6
    xsrc_moves_with_xir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(xsrc_w) |-> (|cpu_xir_o));

    // R10
    blocked_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && !access_w[bus_cpu]) |-> (bus_rdata == '0));
endmodule

bind srst_ctrl srst_ctrl_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_cpu   (bus_cpu),
    .bus_rdata (bus_rdata),
    .access_w  (access_w),
    .psrc_w    (psrc_w),
    .xsrc_w    (xsrc_w),
    .cpu_por_o (cpu_por_o),
    .cpu_xir_o (cpu_xir_o),
    .sys_rst_o (sys_rst_o)
);

// File: tb/srst_ctrl_tb.sv
module srst_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_req = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_cpu = 2'd1;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] cpu_present_i = 4'b1011;
    logic       wdog_i = 1'b0;
    logic       button_i = 1'b0;
    logic       dbg_por_i = 1'b0;
    logic       dbg_xir_i = 1'b0;
    logic       xir_button_i = 1'b0;
    logic [6:0] fatal_i = '0;
    logic       synth_i = 1'b0;
    logic       remote_i = 1'b0;
    logic [3:0] cpu_por_o;
    logic [3:0] cpu_xir_o;
    logic       sys_rst_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    srst_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_cpu(bus_cpu), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cpu_present_i(cpu_present_i),
        .wdog_i(wdog_i), .button_i(button_i), .dbg_por_i(dbg_por_i),
        .dbg_xir_i(dbg_xir_i), .xir_button_i(xir_button_i),
        .fatal_i(fatal_i), .synth_i(synth_i), .remote_i(remote_i),
        .cpu_por_o(cpu_por_o), .cpu_xir_o(cpu_xir_o), .sys_rst_o(sys_rst_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] cpu, input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_cpu = cpu; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; bus_cpu = 2'd1;
    endtask

    task automatic rd(input logic [1:0] cpu, input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_cpu = cpu; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_req = 1'b0; bus_cpu = 2'd1;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] cpu, input logic [3:0] a,
                          input logic [7:0] exp);
        logic [7:0] v;
        rd(cpu, a, v);
        chk(req, 32'(v), 32'(exp));
    endtask

    task automatic psrc_chk(input string req, input logic [17:0] exp);
        logic [7:0] b0, b1, b2;
        rd(2'd1, 4'd6, b0);
        rd(2'd1, 4'd7, b1);
        rd(2'd1, 4'd8, b2);
        chk(req, 32'({b2[1:0], b1, b0}), 32'(exp));
    endtask

    // k: 0 button, 1 debug por, 2 synth, 3 remote, 4 watchdog, 5..11 fatal[k-5]
    task automatic ext(input int k);
        @(negedge clk);
        case (k)
            0: button_i = 1'b1;
            1: dbg_por_i = 1'b1;
            2: synth_i = 1'b1;
            3: remote_i = 1'b1;
            4: wdog_i = 1'b1;
            default: fatal_i[k-5] = 1'b1;
        endcase
        @(negedge clk);
        button_i = 1'b0; dbg_por_i = 1'b0; synth_i = 1'b0; remote_i = 1'b0;
        wdog_i = 1'b0; fatal_i = '0;
    endtask

    function automatic int cause_bit(input int k);
        case (k)
            0: return 6;
            1: return 5;
            2: return 15;
            3: return 17;
            4: return 16;
            default: return 8 + (k - 5);
        endcase
    endfunction

    function automatic bit honoured(input int k, input bit wd_en, input logic [7:0] q);
        if (k == 4) return wd_en;
        if (k >= 5 && k <= 8) return !q[4 + (k - 5)];
        return 1'b1;
    endfunction

    task automatic settle();
        repeat (20) @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [17:0] model;
        logic [7:0]  v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 outputs", 32'({sys_rst_o, cpu_por_o, cpu_xir_o}), 32'h0);
        rd_chk("R1 access", 2'd1, 4'd1, 8'h0F);
        rd_chk("R1 quiesce", 2'd1, 4'd2, 8'h00);
        rd_chk("R1 wdog", 2'd1, 4'd3, 8'h00);
        psrc_chk("R1 psrc power-up", 18'h00080);
        rd_chk("R1 xsrc", 2'd1, 4'd9, 8'h00);

        // R11 presence and unmapped
        rd_chk("R11 presence", 2'd2, 4'd0, 8'h0B);
        wr(2'd1, 4'd0, 8'hFF);
        rd_chk("R11 presence read-only", 2'd1, 4'd0, 8'h0B);
        rd_chk("R11 unmapped a", 2'd1, 4'd10, 8'h00);
        rd_chk("R11 unmapped f", 2'd1, 4'd15, 8'h00);

        // R2 soft per-cpu POR pulse width
        wr(2'd1, 4'd4, 8'h04);
        chk("R2 cpu2 por start", 32'(cpu_por_o), 32'h4);
        chk("R2 no sys", 32'(sys_rst_o), 32'h0);
        repeat (15) @(negedge clk);
        chk("R2 cpu2 por last cycle", 32'(cpu_por_o), 32'h4);
        @(negedge clk);
        chk("R2 cpu2 por self-clear", 32'(cpu_por_o), 32'h0);
        psrc_chk("R5 psrc soft cpu2", 18'h00004);
        wr(2'd0, 4'd4, 8'h03);
        rd_chk("R2 readback", 2'd1, 4'd4, 8'h03);
        settle();
        rd_chk("R2 readback cleared", 2'd1, 4'd4, 8'h00);

        // R3 soft system
        wr(2'd3, 4'd4, 8'h10);
        chk("R3 sys", 32'({sys_rst_o, cpu_por_o}), 32'h1F);
        repeat (15) @(negedge clk);
        chk("R3 sys last cycle", 32'(sys_rst_o), 32'h1);
        @(negedge clk);
        chk("R3 sys cleared", 32'({sys_rst_o, cpu_por_o}), 32'h0);
        psrc_chk("R5 psrc soft sys", 18'h00010);

        // R4 / R6 soft XIR
        wr(2'd1, 4'd5, 8'h03);
        chk("R4 xir start", 32'(cpu_xir_o), 32'h3);
        repeat (15) @(negedge clk);
        chk("R4 xir last", 32'(cpu_xir_o), 32'h3);
        @(negedge clk);
        chk("R4 xir cleared", 32'(cpu_xir_o), 32'h0);
        rd_chk("R6 xsrc soft", 2'd1, 4'd9, 8'h03);

        // R6 debug and button XIR
        @(negedge clk); dbg_xir_i = 1'b1;
        @(negedge clk); dbg_xir_i = 1'b0;
        chk("R6 dbg xir all", 32'(cpu_xir_o), 32'hF);
        rd_chk("R6 xsrc dbg", 2'd1, 4'd9, 8'h10);
        settle();
        @(negedge clk); xir_button_i = 1'b1;
        @(negedge clk); xir_button_i = 1'b0;
        chk("R6 button xir all", 32'(cpu_xir_o), 32'hF);
        rd_chk("R6 xsrc button", 2'd1, 4'd9, 8'h20);
        psrc_chk("R5 psrc untouched by xir", 18'h00010);
        settle();

        // R7 watchdog ignored then honoured
        ext(4);
        chk("R7 wdog ignored", 32'({sys_rst_o, cpu_por_o}), 32'h0);
        psrc_chk("R7 psrc unchanged", 18'h00010);
        wr(2'd1, 4'd3, 8'h01);
        ext(4);
        chk("R7 wdog reset", 32'(sys_rst_o), 32'h1);
        psrc_chk("R7 psrc wdog", 18'h10000);
        settle();

        // R8 external causes
        ext(0); chk("R8 button sys", 32'(sys_rst_o), 32'h1);
        psrc_chk("R5 button", 18'h00040); settle();
        ext(1); psrc_chk("R5 dbg por", 18'h00020); settle();
        ext(2); psrc_chk("R5 synth", 18'h08000); settle();
        ext(3); chk("R8 remote sys", 32'(sys_rst_o), 32'h1);
        psrc_chk("R5 remote", 18'h20000); settle();
        ext(11); psrc_chk("R5 fatal6", 18'h04000); settle();

        // R9 quiesce masking
        wr(2'd1, 4'd2, 8'h15);
        rd_chk("R9 quiesce readback", 2'd1, 4'd2, 8'h15);
        ext(5);
        chk("R9 masked fatal0 no reset", 32'(sys_rst_o), 32'h0);
        psrc_chk("R9 masked fatal0 no source", 18'h04000);
        ext(6);
        chk("R9 fatal1 reset", 32'(sys_rst_o), 32'h1);
        psrc_chk("R9 fatal1 source", 18'h00200);
        settle();

        // R10 arbitration
        wr(2'd0, 4'd1, 8'h0E);
        rd_chk("R10 blocked read", 2'd0, 4'd1, 8'h00);
        wr(2'd0, 4'd4, 8'h01);
        chk("R10 blocked write no reset", 32'(cpu_por_o), 32'h0);
        wr(2'd0, 4'd1, 8'h0F);
        rd_chk("R10 access unchanged", 2'd2, 4'd1, 8'h0E);
        psrc_chk("R10 psrc unchanged", 18'h00200);
        wr(2'd1, 4'd1, 8'h0F);
        rd_chk("R10 restored", 2'd0, 4'd1, 8'h0F);

        // random phase: R7 R8 R9 R5
        model = 18'h00200;
        for (int it = 0; it < 60; it++) begin
            int k;
            bit wd;
            logic [7:0] q;
            bit h;
            wd = 1'($urandom_range(0, 1));
            q  = 8'($urandom_range(0, 255));
            k  = int'($urandom_range(0, 11));
            wr(2'($urandom_range(0, 3)), 4'd3, {7'd0, wd});
            wr(2'($urandom_range(0, 3)), 4'd2, q);
            ext(k);
            h = honoured(k, wd, q);
            if (h) model = 18'(1) << cause_bit(k);
            chk($sformatf("R8 random sys k=%0d", k), 32'(sys_rst_o), 32'(h));
            psrc_chk($sformatf("R5 random psrc k=%0d", k), model);
            settle();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule